// File: doc/BRIEF.md
# Scan-Line Host Access Window

The block marks the interval within each scan line when a host may touch display memory without disturbing the picture. It watches the line-sync input and treats each high-to-low transition as the start of a line. On that transition it emits a one-cycle interrupt pulse. It also loads a down-counter with a window length, and holds the window-open output high while that counter is non-zero.

The window length is computed at the sync transition from four values: the total-characters-per-line count, the displayed-characters-per-line count, the colour depth and the clock divider setting. All four are captured at that moment, so a change made during a line first takes effect on the next line. While the window is open, host requests are granted. A request made while the window is closed gets no grant. It also sets a sticky violation flag, which the host clears with a write-one pulse.

Top module: `line_access_window`

## Requirements
- R1: `irq_o` is high for exactly one cycle. It follows the first rising clock edge at which `line_sync_i` is sampled low after having been sampled high on the previous edge.
- R2: When the computed length L is greater than zero, `window_open_o` rises in the same cycle as `irq_o`. It then stays high for exactly L cycles and drops in the cycle the countdown reaches zero.
- R3: L = ((tcr+1) - (cr+1) - k) × div × 2, counted in cycles of `clk_i`.
- R4: `div_cfg_i` encodes the divider as 00→4, 01→8, 10→16. The reserved code 11 acts as 16.
- R5: `bpp_i` encodes the colour depth and its offset as 00 = 1 bpp (k=3), 01 = 2 bpp (k=2), 10 = 4 bpp (k=1). Code 11 acts as 4 bpp.
- R6: When (tcr - cr - k) ≤ 0, the window stays closed for that line, but `irq_o` still pulses.
- R7: `tcr_i`, `cr_i`, `bpp_i` and `div_cfg_i` are sampled only at the sync edge. Changing them while the window is open does not alter that window's length.
- R8: `host_gnt_o` equals `host_req_i` while the window is open and is low while it is closed.
- R9: A request made while the window is closed sets `viol_o` on the next cycle. The flag holds until a cycle with `viol_clr_i` high and no new violation. A new violation wins over a clear in the same cycle.
- R10: A sync edge that arrives while a window is open restarts the count with the newly computed length.
- R11: After reset, `irq_o`, `window_open_o`, `host_gnt_o` and `viol_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, the time unit of the window |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_sync_i | input | 1 | Line-sync pulse; its falling edge starts a line |
| tcr_i | input | 8 | Total characters per line, minus one |
| cr_i | input | 8 | Displayed characters per line, minus one |
| bpp_i | input | 2 | Colour depth select |
| div_cfg_i | input | 2 | Clock divider select |
| host_req_i | input | 1 | Host memory access request |
| viol_clr_i | input | 1 | Write-one clear of the violation flag |
| window_open_o | output | 1 | Access window open |
| irq_o | output | 1 | One-cycle line-start interrupt |
| host_gnt_o | output | 1 | Host access granted |
| viol_o | output | 1 | Sticky out-of-window request flag |

## Verification
The hardest cases to reach are those where the window is already open when something new arrives. One is a configuration change that must not shorten or lengthen the current window. The other is a second sync edge that must restart the count. The bench sweeps every depth and divider code across a grid of tcr and cr values, including negative and zero differences, and scrambles all four configuration inputs right after each line edge. A dedicated sequence then issues a fresh sync edge partway through a long window and measures the remaining open time from the new interrupt.

// File: rtl/law_pkg.sv
package law_pkg;
  typedef enum logic [1:0] {
    BPP_1 = 2'b00,
    BPP_2 = 2'b01,
    BPP_4 = 2'b10,
    BPP_R = 2'b11
  } bpp_e;

  function automatic logic [1:0] depth_offset(input logic [1:0] sel);
    case (bpp_e'(sel))
      BPP_1:   return 2'd3;
      BPP_2:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // shift for div*2: 4->3, 8->4, 16->5
  function automatic logic [2:0] div_shift(input logic [1:0] cfg);
    case (cfg)
      2'b00:   return 3'd3;
      2'b01:   return 3'd4;
      default: return 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/law_edge_det.sv
module law_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic fall_o,
  output logic irq_o
);
  logic sync_q;

  assign fall_o = sync_q & ~sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      sync_q <= sync_i;
      irq_o  <= fall_o;
    end
  end

  // R1
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/law_len_calc.sv
module law_len_calc
  import law_pkg::*;
#(
  parameter int TW = 8,
  localparam int CW = TW + 5
) (
  input  logic [TW-1:0] tcr_i,
  input  logic [TW-1:0] cr_i,
  input  logic [1:0]    bpp_i,
  input  logic [1:0]    div_cfg_i,
  output logic [CW-1:0] len_o
);
  logic signed [TW+1:0] diff;

  always_comb begin
    diff = $signed({2'b00, tcr_i}) - $signed({2'b00, cr_i})
         - $signed({{TW{1'b0}}, depth_offset(bpp_i)});
    if (diff <= 0) len_o = '0;
    else           len_o = CW'(diff[TW-1:0]) << div_shift(div_cfg_i);
  end
endmodule

// File: rtl/law_win_cnt.sv
module law_win_cnt #(
  parameter int CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          open_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q != '0);

  // R2
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R10
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(len_i)));
endmodule

// File: rtl/law_viol.sv
module law_viol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic open_i,
  input  logic clr_i,
  output logic gnt_o,
  output logic viol_o
);
  logic bad;

  assign bad   = req_i & ~open_i;
  assign gnt_o = req_i & open_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    viol_o <= 1'b0;
    else if (bad)   viol_o <= 1'b1;
    else if (clr_i) viol_o <= 1'b0;
  end

  // R9
  viol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !open_i) |=> viol_o);

  // R9
  viol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !clr_i) |=> viol_o);
endmodule

// File: rtl/line_access_window.sv
module line_access_window #(
  parameter int TW = 8,
  localparam int CW = TW + 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_sync_i,
  input  logic [TW-1:0] tcr_i,
  input  logic [TW-1:0] cr_i,
  input  logic [1:0]    bpp_i,
  input  logic [1:0]    div_cfg_i,
  input  logic          host_req_i,
  input  logic          viol_clr_i,
  output logic          window_open_o,
  output logic          irq_o,
  output logic          host_gnt_o,
  output logic          viol_o
);
  logic          fall;
  logic [CW-1:0] len;

  law_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(line_sync_i),
    .fall_o(fall),
    .irq_o (irq_o)
  );

  law_len_calc #(.TW(TW)) u_len (
    .tcr_i    (tcr_i),
    .cr_i     (cr_i),
    .bpp_i    (bpp_i),
    .div_cfg_i(div_cfg_i),
    .len_o    (len)
  );

  law_win_cnt #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(fall),
    .len_i (len),
    .open_o(window_open_o)
  );

  law_viol u_viol (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (host_req_i),
    .open_i(window_open_o),
    .clr_i (viol_clr_i),
    .gnt_o (host_gnt_o),
    .viol_o(viol_o)
  );

  // R2
  open_at_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(window_open_o) |-> irq_o);

  // R8
  gnt_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> window_open_o);
endmodule

// File: tb/line_access_window_tb.sv
module line_access_window_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [7:0] tcr = '0, cr = '0;
  logic [1:0] bpp = '0, div = '0;
  logic       req = 1'b0, clr = 1'b0;
  logic       win, irq, gnt, viol;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_access_window u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_sync_i(sync),
    .tcr_i(tcr), .cr_i(cr), .bpp_i(bpp), .div_cfg_i(div),
    .host_req_i(req), .viol_clr_i(clr),
    .window_open_o(win), .irq_o(irq), .host_gnt_o(gnt), .viol_o(viol)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(int t, int c, int b, int d);
    int k, dv, x;
    k  = (b == 0) ? 3 : (b == 1) ? 2 : 1;
    dv = (d == 0) ? 4 : (d == 1) ? 8 : 16;
    x  = t - c - k;
    return (x <= 0) ? 0 : x * dv * 2;
  endfunction

  // drive a sync pulse; returns at the negedge where irq should be visible
  task automatic line_edge();
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_line(int t, int c, int b, int d);
    int l, n;
    tcr = 8'(t); cr = 8'(c); bpp = 2'(b); div = 2'(d);
    l = exp_len(t, c, b, d);
    line_edge();
    chk("R1 irq high", int'(irq), 1);
    chk("R2/R6 open at irq", int'(win), (l > 0) ? 1 : 0);
    // R7: scramble config inside the window
    tcr = ~tcr; cr = ~cr; bpp = ~bpp; div = ~div;
    n = win ? 1 : 0;
    @(negedge clk);
    chk("R1 irq one cycle", int'(irq), 0);
    while (win && n < 20000) begin
      n++;
      @(negedge clk);
    end
    // R3 R4 R5 R7
    chk($sformatf("R3 len t=%0d c=%0d b=%0d d=%0d", t, c, b, d), n, l);
  endtask

  initial begin
    int n;
    #1;
    // R11
    chk("R11 irq", int'(irq), 0);
    chk("R11 open", int'(win), 0);
    chk("R11 gnt", int'(gnt), 0);
    chk("R11 viol", int'(viol), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int b = 0; b < 4; b++)
      for (int d = 0; d < 4; d++)
        for (int t = 0; t < 10; t++)
          for (int c = 0; c < 5; c++)
            run_line(t, c, b, d);
    run_line(255, 0, 2, 3);

    // R8 R9: closed-window request
    chk("R8 closed open", int'(win), 0);
    req = 1'b1; #1;
    chk("R8 no gnt closed", int'(gnt), 0);
    @(negedge clk);
    req = 1'b0;
    chk("R9 viol set", int'(viol), 1);
    repeat (3) @(negedge clk);
    chk("R9 viol sticky", int'(viol), 1);
    req = 1'b1; clr = 1'b1;
    @(negedge clk);
    chk("R9 set beats clear", int'(viol), 1);
    req = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    chk("R9 cleared", int'(viol), 0);

    // R8: grant inside window
    tcr = 8'd20; cr = 8'd2; bpp = 2'd2; div = 2'd0;
    line_edge();
    req = 1'b1; #1;
    chk("R8 gnt open", int'(gnt), 1);
    @(negedge clk);
    req = 1'b0;
    chk("R8 no viol in window", int'(viol), 0);

    // R10: restart mid-window with new length
    repeat (5) @(negedge clk);
    tcr = 8'd6; cr = 8'd1; bpp = 2'd1; div = 2'd1;
    line_edge();
    chk("R10 irq restart", int'(irq), 1);
    n = win ? 1 : 0;
    @(negedge clk);
    while (win && n < 20000) begin
      n++;
      @(negedge clk);
    end
    chk("R10 restart len", n, exp_len(6, 1, 1, 1));

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule